// File: doc/BRIEF.md
# Flash Word Programming Sequencer

This block sits on the host side of a NOR-style flash device. It writes a run of consecutive words into the array. The caller gives a start address and a word count, then pulses a start input. For each word, the block fetches the data from a word source through an index/data pair. It issues the four-write program command on an asynchronous address/data/strobe bus. It then reads the target address until the status bit shows that the device's internal program step is done, and reads the word once more to confirm it.

If the word reads back correctly and more words remain, the block moves to the next address and repeats the loop. After the last word it raises done. It raises error, and records the failing address, in two cases. The first is when the device stays busy for more polls than the configured limit. The second is when the read-back data differs from the word that was written. In both cases no further words are touched.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, busy, done and error are low, and both bus strobes (`fl_we_n`, `fl_oe_n`) are high.
- R2: Each word is written with four bus writes in this fixed order: address 0x555 with data 0xAA, address 0x2AA with data 0x55, address 0x555 with data 0xA0, then the target address with the word. Only the low 8 bits of the data bus carry the command codes.
- R3: During a bus write, address and data are held stable for one cycle before a one-cycle low pulse on `fl_we_n`, through that pulse, and for one cycle after it. `fl_we_n` and `fl_oe_n` are never low in the same cycle.
- R4: After the target write, the block reads the target address repeatedly. A read whose bit 7 differs from bit 7 of the written word means the device is busy. A read whose bit 7 equals it means the program step is complete.
- R5: Once polling reports completion, one more read of the target address is made. If it matches the whole written word, the block advances.
- R6: Words go to addresses `start_addr`, `start_addr+1`, ... in order, and word k is taken from the source while `word_idx` equals k. `done` rises only after the last word has been verified, and it stays high until the next start.
- R7: If POLL_MAX consecutive poll reads all show busy, the block stops with `error` high and `err_addr` set to the target address. A completion seen on the POLL_MAX-th read counts as success.
- R8: If the verify read differs from the written word, the block stops with `error` high and `err_addr` set to that address, and it issues no write to any later address.
- R9: A start with `word_count` equal to zero raises `done` without any bus cycle.
- R10: A start pulse while the block is busy is ignored, and the run in progress completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to begin a run when not busy |
| start_addr | input | AW | First word address |
| word_count | input | CW | Number of words to program |
| word_idx | output | CW | Index of the word wanted from the source |
| word_data | input | DW | Source word for `word_idx` |
| busy | output | 1 | Run in progress |
| done | output | 1 | All words programmed and verified |
| error | output | 1 | Run stopped on poll timeout or verify mismatch |
| err_addr | output | AW | Address of the word that failed |
| fl_addr | output | AW | Flash address bus |
| fl_wdata | output | DW | Flash write data |
| fl_rdata | input | DW | Flash read data |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash read strobe, active low |

## Verification
The poll that shows completion and the expiry of the poll limit can land on the same read: the POLL_MAX-th poll. The bench drives this case with a device stub that stays busy for exactly POLL_MAX-1 polls on one word, and then for exactly POLL_MAX polls on another word. The first case must finish with `done` and every word correct. The second must end with `error`, the right `err_addr`, and no program writes beyond the failing word. Random runs with mixed busy lengths and data polarities of bit 7 cover the ordinary path around these edges.

// File: rtl/fseq_pkg.sv
`timescale 1ns/1ps
package fseq_pkg;

  // sequencer states, one per bus operation of the per-word loop
  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_UNL1, S_UNL2, S_SETUP, S_PROG,
    S_POLL, S_VERIFY, S_NEXT, S_DONE, S_FAIL
  } seq_state_t;

  // bus cycle phases
  typedef enum logic [1:0] {
    PH_IDLE, PH_LEAD, PH_STROBE, PH_TRAIL
  } bus_phase_t;

  localparam int unsigned CMD_ADDR_A = 32'h555;
  localparam int unsigned CMD_ADDR_B = 32'h2AA;
  localparam logic [7:0]  CMD_UNL1   = 8'hAA;
  localparam logic [7:0]  CMD_UNL2   = 8'h55;
  localparam logic [7:0]  CMD_PROG   = 8'hA0;

endpackage

// File: rtl/fseq_bus_phy.sv
`timescale 1ns/1ps
module fseq_bus_phy
  import fseq_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_req,
  input  logic          op_read,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_wdata,
  output logic          op_ack,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  output logic          fl_we_n,
  output logic          fl_oe_n
);

  bus_phase_t    ph_q, ph_d;
  logic          rd_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          load;

  always_comb begin
    ph_d = ph_q;
    load = 1'b0;
    unique case (ph_q)
      PH_IDLE:   if (op_req) begin
                   load = 1'b1;
                   ph_d = PH_LEAD;
                 end
      PH_LEAD:   ph_d = PH_STROBE;
      PH_STROBE: ph_d = rd_q ? PH_IDLE : PH_TRAIL;
      PH_TRAIL:  ph_d = PH_IDLE;
      default:   ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      rd_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (load) begin
        rd_q   <= op_read;
        addr_q <= op_addr;
        data_q <= op_wdata;
      end
    end
  end

  assign op_ack   = (ph_q == PH_TRAIL) || ((ph_q == PH_STROBE) && rd_q);
  assign fl_addr  = addr_q;
  assign fl_wdata = data_q;
  assign fl_we_n  = !((ph_q == PH_STROBE) && !rd_q);
  assign fl_oe_n  = !(rd_q && ((ph_q == PH_LEAD) || (ph_q == PH_STROBE)));

  // R3
  strobe_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_wdata)));
  // R3
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_wdata)));
  // R3
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |=> fl_we_n);
  // R3
  no_bus_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n));

endmodule

// File: rtl/fseq_poll_timer.sv
`timescale 1ns/1ps
module fseq_poll_timer #(
  parameter int POLL_MAX = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic expired
);

  localparam int CNT_W = $clog2(POLL_MAX + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(POLL_MAX - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expired = tick && (cnt_q == LAST);
  assign cnt_en  = clr || (tick && !expired);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R7
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(POLL_MAX));

endmodule

// File: rtl/flash_prog_seq.sv
`timescale 1ns/1ps
module flash_prog_seq
  import fseq_pkg::*;
#(
  parameter int AW       = 20,
  parameter int DW       = 16,
  parameter int CW       = 16,
  parameter int POLL_MAX = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] word_count,
  output logic [CW-1:0] word_idx,
  input  logic [DW-1:0] word_data,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic [AW-1:0] err_addr,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  input  logic [DW-1:0] fl_rdata,
  output logic          fl_we_n,
  output logic          fl_oe_n
);

  localparam logic [AW-1:0] ADDR_A = AW'(CMD_ADDR_A);
  localparam logic [AW-1:0] ADDR_B = AW'(CMD_ADDR_B);

  seq_state_t    st_q, st_d;
  logic [AW-1:0] addr_q, addr_d, eaddr_q, eaddr_d;
  logic [CW-1:0] idx_q, idx_d, left_q, left_d;
  logic [DW-1:0] word_q, word_d;

  logic          op_req, op_read, op_ack;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_wdata;
  logic          t_clr, t_tick, t_expired;

  fseq_bus_phy #(.AW(AW), .DW(DW)) i_phy (
    .clk(clk), .rst_n(rst_n),
    .op_req(op_req), .op_read(op_read), .op_addr(op_addr), .op_wdata(op_wdata),
    .op_ack(op_ack),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  fseq_poll_timer #(.POLL_MAX(POLL_MAX)) i_timer (
    .clk(clk), .rst_n(rst_n), .clr(t_clr), .tick(t_tick), .expired(t_expired)
  );

  always_comb begin
    st_d     = st_q;
    addr_d   = addr_q;
    idx_d    = idx_q;
    left_d   = left_q;
    word_d   = word_q;
    eaddr_d  = eaddr_q;
    op_req   = 1'b0;
    op_read  = 1'b0;
    op_addr  = addr_q;
    op_wdata = word_q;
    t_clr    = 1'b0;
    t_tick   = 1'b0;
    unique case (st_q)
      S_IDLE, S_DONE, S_FAIL: if (start) begin
        if (word_count == '0) begin
          st_d = S_DONE;
        end else begin
          addr_d = start_addr;
          idx_d  = '0;
          left_d = word_count;
          st_d   = S_FETCH;
        end
      end
      S_FETCH: begin
        word_d = word_data;
        t_clr  = 1'b1;
        st_d   = S_UNL1;
      end
      S_UNL1: begin
        op_req = 1'b1; op_addr = ADDR_A; op_wdata = DW'(CMD_UNL1);
        if (op_ack) st_d = S_UNL2;
      end
      S_UNL2: begin
        op_req = 1'b1; op_addr = ADDR_B; op_wdata = DW'(CMD_UNL2);
        if (op_ack) st_d = S_SETUP;
      end
      S_SETUP: begin
        op_req = 1'b1; op_addr = ADDR_A; op_wdata = DW'(CMD_PROG);
        if (op_ack) st_d = S_PROG;
      end
      S_PROG: begin
        op_req = 1'b1;
        if (op_ack) st_d = S_POLL;
      end
      S_POLL: begin
        op_req = 1'b1; op_read = 1'b1;
        if (op_ack) begin
          if (fl_rdata[7] == word_q[7]) begin
            st_d = S_VERIFY;
          end else begin
            t_tick = 1'b1;
            if (t_expired) begin
              st_d    = S_FAIL;
              eaddr_d = addr_q;
            end
          end
        end
      end
      S_VERIFY: begin
        op_req = 1'b1; op_read = 1'b1;
        if (op_ack) begin
          if (fl_rdata == word_q) begin
            st_d = S_NEXT;
          end else begin
            st_d    = S_FAIL;
            eaddr_d = addr_q;
          end
        end
      end
      S_NEXT: begin
        if (left_q == CW'(1)) begin
          st_d = S_DONE;
        end else begin
          addr_d = addr_q + 1'b1;
          idx_d  = idx_q + 1'b1;
          left_d = left_q - 1'b1;
          st_d   = S_FETCH;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      addr_q  <= '0;
      idx_q   <= '0;
      left_q  <= '0;
      word_q  <= '0;
      eaddr_q <= '0;
    end else begin
      st_q    <= st_d;
      addr_q  <= addr_d;
      idx_q   <= idx_d;
      left_q  <= left_d;
      word_q  <= word_d;
      eaddr_q <= eaddr_d;
    end
  end

  assign word_idx = idx_q;
  assign busy     = !((st_q == S_IDLE) || (st_q == S_DONE) || (st_q == S_FAIL));
  assign done     = (st_q == S_DONE);
  assign error    = (st_q == S_FAIL);
  assign err_addr = eaddr_q;

  // R6
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  // R8
  fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (fl_we_n && fl_oe_n));
  // R6
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fl_we_n && fl_oe_n && !busy));

endmodule

// File: tb/test_flash_prog_seq.sv
`timescale 1ns/1ps
module test_flash_prog_seq;

  localparam int AW = 20, DW = 16, CW = 16, PMAX = 8;

  logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] word_count = '0;
  logic [CW-1:0] word_idx;
  logic [DW-1:0] word_data;
  logic          busy, done, error;
  logic [AW-1:0] err_addr, fl_addr;
  logic [DW-1:0] fl_wdata, fl_rdata;
  logic          fl_we_n, fl_oe_n;

  always #2.5 clk = ~clk;

  flash_prog_seq #(.AW(AW), .DW(DW), .CW(CW), .POLL_MAX(PMAX)) i_flash_prog_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .word_count(word_count), .word_idx(word_idx), .word_data(word_data),
    .busy(busy), .done(done), .error(error), .err_addr(err_addr),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
    .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  int tests = 0, fails = 0, cycles = 0;
  logic [DW-1:0] src [16];
  int busy_tab [16];
  int corrupt_k = -1;
  assign word_data = src[word_idx[3:0]];

  // behavioural flash stub, evaluated mid-cycle
  logic [DW-1:0] fmem [256];
  logic          clr_stub = 1'b0;
  int ucnt = 0, busy_left = 0, prog_ops = 0, perr = 0, terr = 0;
  logic [AW-1:0] prog_addr = '0, pa_prev = '0, strobe_addr = '0;
  logic [DW-1:0] prog_data = '0, pd_prev = '0;
  logic          oe_prev = 1'b1, hold_pend = 1'b0;

  always @(negedge clk) begin
    if (clr_stub) begin
      for (int i = 0; i < 256; i++) fmem[i] = 16'hFFFF;
      ucnt = 0; busy_left = 0; prog_ops = 0; perr = 0; terr = 0;
    end else if (rst_n) begin
      if (hold_pend) begin
        if (!fl_we_n || fl_addr != strobe_addr) terr++;
        hold_pend = 1'b0;
      end
      if (!fl_we_n && !fl_oe_n) terr++;
      if (!fl_we_n) begin
        if (fl_addr != pa_prev || fl_wdata != pd_prev) terr++;
        strobe_addr = fl_addr;
        hold_pend   = 1'b1;
        if (busy_left > 0) perr++;
        case (ucnt)
          0: if (fl_addr == 20'h555 && fl_wdata[7:0] == 8'hAA) ucnt = 1; else perr++;
          1: if (fl_addr == 20'h2AA && fl_wdata[7:0] == 8'h55) ucnt = 2; else begin perr++; ucnt = 0; end
          2: if (fl_addr == 20'h555 && fl_wdata[7:0] == 8'hA0) ucnt = 3; else begin perr++; ucnt = 0; end
          default: begin
            prog_addr = fl_addr;
            prog_data = fl_wdata;
            fmem[fl_addr[7:0]] = (prog_ops == corrupt_k) ? (fl_wdata ^ 16'h0001) : fl_wdata;
            busy_left = busy_tab[prog_ops & 15];
            prog_ops++;
            ucnt = 0;
          end
        endcase
      end
      if (fl_oe_n && !oe_prev && busy_left > 0) busy_left--;
      oe_prev = fl_oe_n;
      pa_prev = fl_addr;
      pd_prev = fl_wdata;
    end
  end

  always_comb begin
    fl_rdata = fmem[fl_addr[7:0]];
    if (busy_left > 0 && fl_addr == prog_addr) fl_rdata[7] = ~prog_data[7];
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic clear_stub();
    @(negedge clk); clr_stub = 1'b1;
    @(negedge clk); clr_stub = 1'b0;
  endtask

  // runs one case; the expected outcome is derived from busy_tab/corrupt_k
  task automatic run_case(input logic [AW-1:0] sa, input int cnt, input int mid_start);
    int fk, w;
    fk = -1;
    for (int k = 0; k < cnt; k++)
      if (fk < 0 && (busy_tab[k] >= PMAX || k == corrupt_k)) fk = k;
    clear_stub();
    start_addr = sa; word_count = CW'(cnt); start = 1'b1;
    @(negedge clk); start = 1'b0;
    w = 0;
    while (!done && !error && w < 20000) begin
      @(negedge clk); w++;
      if (w == mid_start) begin
        start_addr = sa + 20'h80; word_count = 16'd2; start = 1'b1;
        @(negedge clk); start = 1'b0; start_addr = sa; w++;
      end
    end
    chk(perr == 0, "R2 command order errors", perr, 0);
    chk(terr == 0, "R3 strobe timing errors", terr, 0);
    if (fk < 0) begin
      chk(done && !error, "R6 done at end", {done, error}, 2'b10);
      chk(prog_ops == cnt, "R6 program count", prog_ops, cnt);
      for (int k = 0; k < cnt; k++)
        chk(fmem[(sa + k) & 255] == src[k], "R5 word contents", fmem[(sa + k) & 255], src[k]);
      repeat (3) @(negedge clk);
      chk(done, "R6 done held", done, 1);
    end else begin
      chk(error && !done, "R7/R8 error raised", {done, error}, 2'b01);
      chk(err_addr == sa + fk, "R7/R8 err_addr", err_addr, sa + fk);
      chk(prog_ops == fk + 1, "R8 no later writes", prog_ops, fk + 1);
      if (fk + 1 < cnt)
        chk(fmem[(sa + fk + 1) & 255] == 16'hFFFF, "R8 next word untouched",
            fmem[(sa + fk + 1) & 255], 16'hFFFF);
    end
    if (mid_start > 0)
      chk(fmem[(sa + 20'h80) & 255] == 16'hFFFF, "R10 mid-run start ignored",
          fmem[(sa + 20'h80) & 255], 16'hFFFF);
  endtask

  initial begin
    int seed, n;
    logic [AW-1:0] a;
    seed = 32'h5EED1234;
    void'($urandom(seed));
    for (int i = 0; i < 256; i++) fmem[i] = 16'hFFFF;
    for (int k = 0; k < 16; k++) begin src[k] = '0; busy_tab[k] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !error, "R1 status after reset", {busy, done, error}, 0);
    chk(fl_we_n && fl_oe_n, "R1 strobes after reset", {fl_we_n, fl_oe_n}, 2'b11);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !error, "R1 idle after release", {busy, done, error}, 0);

    // random runs: R2 R4 R5 R6
    for (int r = 0; r < 8; r++) begin
      n = 1 + ($urandom % 6);
      a = 20'h1000 + ($urandom % 200);
      for (int k = 0; k < 16; k++) begin
        src[k] = DW'($urandom);
        busy_tab[k] = $urandom % 6;
      end
      corrupt_k = -1;
      run_case(a, n, 0);
    end

    // R4 completion on a zero-busy word and a long-busy word
    for (int k = 0; k < 16; k++) busy_tab[k] = 0;
    src[0] = 16'h0080; src[1] = 16'h7F7F; busy_tab[1] = 5;
    run_case(20'h2010, 2, 0);

    // R7 completion on the last allowed poll counts as success
    busy_tab[0] = 1; busy_tab[1] = PMAX - 1; busy_tab[2] = 0;
    src[0] = 16'h1234; src[1] = 16'h00FF; src[2] = 16'hA5A5;
    run_case(20'h3020, 3, 0);

    // R7 timeout on the limit itself
    busy_tab[1] = PMAX;
    run_case(20'h3040, 3, 0);

    // R8 verify mismatch
    for (int k = 0; k < 16; k++) busy_tab[k] = 2;
    corrupt_k = 2;
    run_case(20'h4000, 4, 0);
    corrupt_k = -1;

    // R10 start while busy
    run_case(20'h5008, 3, 25);

    // R9 zero count
    clear_stub();
    word_count = '0; start_addr = 20'h6000; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(done && !error, "R9 done on zero count", {done, error}, 2'b10);
    repeat (4) @(negedge clk);
    chk(prog_ops == 0 && fl_we_n && fl_oe_n, "R9 no bus cycles", prog_ops, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule